// File: doc/BRIEF.md
# Sector Protection and Input Status Register Bank

This block holds the per-sector protection state of a sector-organised flash array and exposes it through the register space of the host bus interface. Each sector has one small protection register with two bits. One bit stops writes to that sector and the other stops reads from it. The bank turns these bits into two flag vectors, read-allowed and write-allowed, with one bit per sector. The command engine uses the write flags and the read path uses the read flags.

Two active-low hardware protect inputs are folded into the write flags. One guards only the topmost (boot) sector. The other guards every remaining sector. A further read-only register returns the live level of the general-purpose input pins and stores nothing. The block also gates the array read data: a read from a read-locked sector yields zero.

Top module: `sector_guard`

## Requirements
- R1: After reset every protection register holds 00h, so every sector is readable, and every sector is writable while both protect inputs are high.
- R2: The protection register of sector s is at register address (s << 16) | 2. A write strobe (regSel and regWr high at a rising clock edge) to that address stores wrData[1:0] into it.
- R3: Bit 0 of a protection register is the write lock. When it is set, writeAllow[s] is low from the cycle after the write.
- R4: Bit 1 of a protection register is the read lock. When it is set, readAllow[s] is low from the cycle after the write.
- R5: While topProtN is low, writeAllow of the highest sector is low. The other sectors are unaffected, and the effect is in the same cycle.
- R6: While restProtN is low, writeAllow of every sector except the highest is low. The highest sector is unaffected, and the effect is in the same cycle.
- R7: A read strobe (regSel and regRd high at a rising edge) to a protection register address places that register zero-extended to 8 bits on rdData after that edge. rdData holds its value until the next read strobe.
- R8: A read strobe to address 0x00100 places the levels the gpiPins inputs had at that edge in rdData[4:0], with zeros in rdData[7:5].
- R9: Bits 7:2 of a write are dropped and read back as zero. Writes to any address other than a protection register address leave all protection state unchanged, and that includes the input status address and offset 3.
- R10: A read strobe to an address that maps to no register returns 00h.
- R11: arrRdGated equals arrRdData when readAllow[arrRdSector] is high and 00h when it is low, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register-space access select |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regAddr | input | 20 | Register address within the register space |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| gpiPins | input | 5 | General-purpose input levels |
| topProtN | input | 1 | Boot-sector write protect, active low |
| restProtN | input | 1 | Write protect for all other sectors, active low |
| arrRdSector | input | 4 | Sector of the current array read |
| arrRdData | input | 8 | Raw array read data |
| arrRdGated | output | 8 | Array data after read-lock gating |
| readAllow | output | 16 | Per-sector read permission |
| writeAllow | output | 16 | Per-sector write permission |

## Verification
Random writes of full bytes to random sectors, mixed with random toggling of both protect inputs, show whether the lock bits and the pins combine per sector. They also show whether the boot-sector pin is kept apart from the other pin. Writes with random offsets and to the input status address show whether the address decode leaks into the protection state. Read-back of every register after random updates separates stored bits from dropped upper bits. Changing input levels before each status read tells a live pass-through apart from a stored copy.

// File: rtl/sector_guard_pkg.sv
package sector_guard_pkg;
  localparam int LOCK_BITS = 2;
  localparam int WL_BIT    = 0;
  localparam int RL_BIT    = 1;

  typedef struct packed {
    logic lockWr;
    logic lockRd;
    logic gpiRd;
    logic anyRd;
  } strobes_t;
endpackage

// File: rtl/sector_guard_ctrl.sv
module sector_guard_ctrl
  import sector_guard_pkg::*;
#(
  parameter int SECTOR_CNT  = 16,
  parameter int SECT_AW     = 16,
  parameter int DATA_W      = 8,
  parameter int LOCK_OFFSET = 2,
  parameter int GPI_ADDR    = 'h100,
  localparam int IDX_W      = $clog2(SECTOR_CNT),
  localparam int ADDR_W     = IDX_W + SECT_AW
) (
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output strobes_t          strb,
  output logic [IDX_W-1:0]  idx,
  output logic [LOCK_BITS-1:0] lockVal
);
  localparam logic [ADDR_W-1:0]  GPI_ADDR_L = ADDR_W'(GPI_ADDR);
  localparam logic [SECT_AW-1:0] LOCK_OFF_L = SECT_AW'(LOCK_OFFSET);

  logic lockHit;
  logic gpiHit;
  logic unusedHigh;

  assign lockHit    = regAddr[SECT_AW-1:0] == LOCK_OFF_L;
  assign gpiHit     = regAddr == GPI_ADDR_L;
  assign idx        = regAddr[ADDR_W-1:SECT_AW];
  assign lockVal    = wrData[LOCK_BITS-1:0];
  assign unusedHigh = ^wrData[DATA_W-1:LOCK_BITS];

  always_comb begin
    strb.lockWr = regSel && regWr && lockHit;
    strb.lockRd = regSel && regRd && lockHit;
    strb.gpiRd  = regSel && regRd && gpiHit && !lockHit;
    strb.anyRd  = regSel && regRd;
  end
endmodule

// File: rtl/sector_guard_dp.sv
module sector_guard_dp
  import sector_guard_pkg::*;
#(
  parameter int SECTOR_CNT = 16,
  parameter int DATA_W     = 8,
  parameter int GPI_W      = 5,
  localparam int IDX_W     = $clog2(SECTOR_CNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [IDX_W-1:0]     idx,
  input  logic [LOCK_BITS-1:0] lockVal,
  input  logic [GPI_W-1:0]     gpiPins,
  input  logic                 topProtN,
  input  logic                 restProtN,
  input  logic [IDX_W-1:0]     arrRdSector,
  input  logic [DATA_W-1:0]    arrRdData,
  output logic [DATA_W-1:0]    arrRdGated,
  output logic [DATA_W-1:0]    rdData,
  output logic [SECTOR_CNT-1:0] readAllow,
  output logic [SECTOR_CNT-1:0] writeAllow
);
  logic [LOCK_BITS-1:0] lockQ [SECTOR_CNT];
  logic [DATA_W-1:0]    rdNext;

  for (genvar g = 0; g < SECTOR_CNT; g++) begin : g_sector
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lockQ[g] <= '0;
      else if (strb.lockWr && idx == IDX_W'(g))
        lockQ[g] <= lockVal;
    end

    assign readAllow[g] = ~lockQ[g][RL_BIT];

    if (g == SECTOR_CNT - 1) begin : g_boot
      assign writeAllow[g] = ~lockQ[g][WL_BIT] & topProtN;
    end else begin : g_rest
      assign writeAllow[g] = ~lockQ[g][WL_BIT] & restProtN;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.lockRd)
      rdNext = DATA_W'(lockQ[idx]);
    else if (strb.gpiRd)
      rdNext = DATA_W'(gpiPins);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (strb.anyRd)
      rdData <= rdNext;
  end

  assign arrRdGated = readAllow[arrRdSector] ? arrRdData : '0;
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sector_guard_pkg::*;
#(
  parameter int SECTOR_CNT  = 16,
  parameter int SECT_AW     = 16,
  parameter int DATA_W      = 8,
  parameter int GPI_W       = 5,
  parameter int LOCK_OFFSET = 2,
  parameter int GPI_ADDR    = 'h100,
  localparam int IDX_W      = $clog2(SECTOR_CNT),
  localparam int ADDR_W     = IDX_W + SECT_AW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regSel,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic [GPI_W-1:0]      gpiPins,
  input  logic                  topProtN,
  input  logic                  restProtN,
  input  logic [IDX_W-1:0]      arrRdSector,
  input  logic [DATA_W-1:0]     arrRdData,
  output logic [DATA_W-1:0]     arrRdGated,
  output logic [SECTOR_CNT-1:0] readAllow,
  output logic [SECTOR_CNT-1:0] writeAllow
);
  strobes_t             strb;
  logic [IDX_W-1:0]     idx;
  logic [LOCK_BITS-1:0] lockVal;

  sector_guard_ctrl #(
    .SECTOR_CNT(SECTOR_CNT), .SECT_AW(SECT_AW), .DATA_W(DATA_W),
    .LOCK_OFFSET(LOCK_OFFSET), .GPI_ADDR(GPI_ADDR)
  ) i_ctrl (
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData), .strb(strb), .idx(idx), .lockVal(lockVal)
  );

  sector_guard_dp #(
    .SECTOR_CNT(SECTOR_CNT), .DATA_W(DATA_W), .GPI_W(GPI_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .lockVal(lockVal),
    .gpiPins(gpiPins), .topProtN(topProtN), .restProtN(restProtN),
    .arrRdSector(arrRdSector), .arrRdData(arrRdData), .arrRdGated(arrRdGated),
    .rdData(rdData), .readAllow(readAllow), .writeAllow(writeAllow)
  );
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int SECTOR_CNT  = 16,
  parameter int SECT_AW     = 16,
  parameter int DATA_W      = 8,
  parameter int GPI_W       = 5,
  parameter int LOCK_OFFSET = 2,
  parameter int GPI_ADDR    = 'h100,
  localparam int IDX_W      = $clog2(SECTOR_CNT),
  localparam int ADDR_W     = IDX_W + SECT_AW
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regSel,
  input logic                  regWr,
  input logic                  regRd,
  input logic [ADDR_W-1:0]     regAddr,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     rdData,
  input logic [GPI_W-1:0]      gpiPins,
  input logic                  topProtN,
  input logic                  restProtN,
  input logic [IDX_W-1:0]      arrRdSector,
  input logic [DATA_W-1:0]     arrRdData,
  input logic [DATA_W-1:0]     arrRdGated,
  input logic [SECTOR_CNT-1:0] readAllow,
  input logic [SECTOR_CNT-1:0] writeAllow
);
  logic lockWrite;
  assign lockWrite = regSel && regWr && regAddr[SECT_AW-1:0] == SECT_AW'(LOCK_OFFSET);

  // R3
  wr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockWrite && wrData[0]) |=> !writeAllow[$past(regAddr[ADDR_W-1:SECT_AW])]);

  // R4
  rd_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockWrite && wrData[1]) |=> !readAllow[$past(regAddr[ADDR_W-1:SECT_AW])]);

  // R5
  top_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !topProtN |-> !writeAllow[SECTOR_CNT-1]);

  // R6
  rest_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !restProtN |-> (writeAllow[SECTOR_CNT-2:0] == '0));

  // R8
  gpi_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regRd && regAddr == ADDR_W'(GPI_ADDR)) |=> rdData == DATA_W'($past(gpiPins)));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockWrite |=> $stable(readAllow));

  // R11
  arr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readAllow[arrRdSector] |-> arrRdGated == '0);
endmodule

bind sector_guard sector_guard_chk #(
  .SECTOR_CNT(SECTOR_CNT), .SECT_AW(SECT_AW), .DATA_W(DATA_W), .GPI_W(GPI_W),
  .LOCK_OFFSET(LOCK_OFFSET), .GPI_ADDR(GPI_ADDR)
) i_sector_guard_chk (.*);

// File: tb/test_sector_guard.sv
module test_sector_guard;
  localparam int N  = 16;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rstN;
  logic regSel, regWr, regRd;
  logic [AW-1:0] regAddr;
  logic [7:0] wrData, rdData, arrRdData, arrRdGated;
  logic [4:0] gpiPins;
  logic topProtN, restProtN;
  logic [3:0] arrRdSector;
  logic [N-1:0] readAllow, writeAllow;

  int checks = 0;
  int fails  = 0;
  logic [1:0] mLock [N];

  always #5 clk = ~clk;

  sector_guard i_sector_guard (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .gpiPins(gpiPins),
    .topProtN(topProtN), .restProtN(restProtN), .arrRdSector(arrRdSector),
    .arrRdData(arrRdData), .arrRdGated(arrRdGated), .readAllow(readAllow),
    .writeAllow(writeAllow)
  );

  function automatic logic [N-1:0] expRead();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = ~mLock[i][1];
    return r;
  endfunction

  function automatic logic [N-1:0] expWrite();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = ~mLock[i][0] & ((i == N - 1) ? topProtN : restProtN);
    return r;
  endfunction

  function automatic logic [AW-1:0] lockAddr(int s);
    return AW'((s << 16) | 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkOutputs(string tag);
    logic [7:0] d;
    logic [3:0] s;
    chk({tag, " readAllow"}, 32'(readAllow), 32'(expRead()));
    chk({tag, " writeAllow"}, 32'(writeAllow), 32'(expWrite()));
    s = 4'($urandom_range(0, N - 1));
    d = 8'($urandom_range(1, 255));
    arrRdSector = s;
    arrRdData = d;
    #1;
    chk("R11 gate", 32'(arrRdGated), mLock[s][1] ? 32'h0 : 32'(d));
  endtask

  task automatic regWrite(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    regSel = 1; regWr = 1; regRd = 0; regAddr = a; wrData = d;
    @(negedge clk);
    regSel = 0; regWr = 0;
    if (a[15:0] == 16'h2) mLock[a[19:16]] = d[1:0];
  endtask

  task automatic regRead(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    regSel = 1; regRd = 1; regWr = 0; regAddr = a;
    @(negedge clk);
    regSel = 0; regRd = 0;
    d = rdData;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed));
    rstN = 0; regSel = 0; regWr = 0; regRd = 0; regAddr = '0; wrData = '0;
    gpiPins = '0; topProtN = 1; restProtN = 1; arrRdSector = '0; arrRdData = '0;
    for (int i = 0; i < N; i++) mLock[i] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    chk("R1 readAllow", 32'(readAllow), 32'hffff);
    chk("R1 writeAllow", 32'(writeAllow), 32'hffff);
    chk("R1 rdData", 32'(rdData), 0);

    regWrite(lockAddr(5), 8'h01);
    checkOutputs("R3");
    chk("R3 sector5", 32'(writeAllow[5]), 0);
    regWrite(lockAddr(9), 8'h02);
    checkOutputs("R4");
    chk("R4 sector9", 32'(readAllow[9]), 0);
    regRead(lockAddr(5), d); chk("R7 read5", 32'(d), 32'h01);
    regRead(lockAddr(9), d); chk("R2 read9", 32'(d), 32'h02);
    @(negedge clk); chk("R7 hold", 32'(rdData), 32'h02);

    regWrite(lockAddr(3), 8'hff);
    regRead(lockAddr(3), d); chk("R9 upper bits", 32'(d), 32'h03);
    regWrite(AW'((4 << 16) | 3), 8'h03);
    checkOutputs("R9 offset3");
    regWrite(AW'('h100), 8'h03);
    checkOutputs("R9 gpi write");

    gpiPins = 5'h15;
    regRead(AW'('h100), d); chk("R8 gpi", 32'(d), 32'h15);
    gpiPins = 5'h0a;
    regRead(AW'('h100), d); chk("R8 gpi live", 32'(d), 32'h0a);
    regRead(AW'('h7_0040), d); chk("R10 unmapped", 32'(d), 0);

    @(negedge clk) topProtN = 0; #1;
    checkOutputs("R5");
    chk("R5 top", 32'(writeAllow[N-1]), 0);
    @(negedge clk) begin topProtN = 1; restProtN = 0; end #1;
    checkOutputs("R6");
    chk("R6 top open", 32'(writeAllow[N-1]), 1);
    restProtN = 1;

    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      topProtN = 1'($urandom_range(0, 3) != 0);
      restProtN = 1'($urandom_range(0, 3) != 0);
      gpiPins = 5'($urandom);
      if (op < 5) begin
        logic [15:0] off;
        off = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h2;
        regWrite(AW'(($urandom_range(0, N - 1) << 16) | off), 8'($urandom));
        checkOutputs("R2 R3 R4 R9 random");
      end else if (op < 8) begin
        int s;
        s = $urandom_range(0, N - 1);
        regRead(lockAddr(s), d);
        chk("R7 random read", 32'(d), 32'(mLock[s]));
      end else begin
        logic [4:0] p;
        p = gpiPins;
        regRead(AW'('h100), d);
        chk("R8 random gpi", 32'(d), 32'(p));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule